// File: doc/BRIEF.md
# Program and Pattern Bank Address Translator

This block turns the banking control registers of a cartridge memory controller, together with the current processor and video addresses, into physical addresses for the program ROM and the pattern memory. It also produces the nametable-select address line that sets how the two internal screen pages are mirrored. The registers are loaded elsewhere, and the memories and the work-RAM enable lie outside the block.

The program space of 32K is split into two 16K windows, selected by processor address bit 14. Three program modes choose which window follows the bank register and which is fixed. A bit of the first pattern register adds an outer 256K step to every program bank. Pattern memory is mapped either as one 8K bank or as two independent 4K halves. Size masks trim each bank number to the memory actually fitted. All results are registered once, so a new address appears one clock after its inputs.

Top module: `bank_xlat`

## Requirements
- R1: All three outputs are registered: a value appears on the clock edge after the inputs that produce it are sampled, and while `rst_n` is low all outputs are 0.
- R2: `prg_rom_addr[13:0]` equals `cpu_addr[13:0]`, and `prg_rom_addr[18:14]` carries the 16K bank number.
- R3: With `mode_reg[3:2]` = 3, the window at `cpu_addr[14]` = 0 uses bank `prg_sel` and the window at `cpu_addr[14]` = 1 uses bank 15.
- R4: With `mode_reg[3:2]` = 2, the window at `cpu_addr[14]` = 0 uses bank 0 and the window at `cpu_addr[14]` = 1 uses bank `prg_sel`.
- R5: With `mode_reg[3:2]` = 0 or 1, the bank is `prg_sel` with its lowest bit replaced by `cpu_addr[14]` (an even/odd 32K pair).
- R6: `pat0_reg[4]` = 1 adds 16 to the program bank in every program mode.
- R7: The program bank is ANDed with `prg_mask` (number of 16K banks minus 1) before it leaves the block.
- R8: With `mode_reg[4]` = 1, `chr_addr` = {bank, `ppu_addr[11:0]`}, where bank is `pat0_reg` for `ppu_addr[12]` = 0 and `pat1_reg` for `ppu_addr[12]` = 1, ANDed with `chr_mask` (number of 4K banks minus 1).
- R9: With `mode_reg[4]` = 0, `chr_addr` = {`pat0_reg[4:1]` AND `chr_mask[4:1]`, `ppu_addr[12:0]`}, and `pat1_reg` has no effect.
- R10: `nt_a10` follows `mode_reg[1:0]`: 0 gives 0, 1 gives 1, 2 gives `ppu_addr[10]`, 3 gives `ppu_addr[11]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_reg | input | 5 | Control register: mirroring [1:0], program mode [3:2], pattern 4K mode [4] |
| pat0_reg | input | 5 | First pattern bank register; bit 4 also selects the outer program bank |
| pat1_reg | input | 5 | Second pattern bank register (upper 4K half) |
| prg_sel | input | 4 | Program bank field of the program register |
| cpu_addr | input | 15 | Processor address bits 14:0 inside the program space |
| ppu_addr | input | 13 | Video address bits 12:0 |
| prg_mask | input | 5 | Program bank mask in 16K units |
| chr_mask | input | 5 | Pattern bank mask in 4K units |
| prg_rom_addr | output | 19 | Physical program ROM address |
| chr_addr | output | 17 | Physical pattern memory address |
| nt_a10 | output | 1 | Nametable page select line |

## Verification
A wrong mode decode or a lost outer bit shows at the ports as a program address in the wrong 16K bank, visible on the very next clock after the offending inputs, because there is no state beyond the output register. Each vector therefore is compared exactly one cycle after it is applied, covering every program mode in both windows, both pattern modes in both halves, all four mirror settings, and masks narrower than the register fields. A stale or misrouted register input appears as an address that follows the previous vector rather than the current one.

// File: rtl/bank_xlat_pkg.sv
package bank_xlat_pkg;

    localparam int REG_W      = 5;
    localparam int PRG_WIN_W  = 14;
    localparam int CHR_PAGE_W = 12;
    localparam int PBANK_W    = 5;
    localparam int CBANK_W    = 5;

    typedef enum logic [1:0] {
        PM_WIDE_A = 2'b00,
        PM_WIDE_B = 2'b01,
        PM_FIX_LO = 2'b10,
        PM_FIX_HI = 2'b11
    } prg_mode_e;

    typedef enum logic [1:0] {
        NT_ONE_LO = 2'b00,
        NT_ONE_HI = 2'b01,
        NT_VERT   = 2'b10,
        NT_HORZ   = 2'b11
    } nt_mode_e;

    typedef struct packed {
        logic [PBANK_W+PRG_WIN_W-1:0]  prg;
        logic [CBANK_W+CHR_PAGE_W-1:0] chr;
        logic                          nt;
    } xlat_t;

endpackage

// File: rtl/prg_bank_sel.sv
module prg_bank_sel
    import bank_xlat_pkg::*;
#(
    parameter int BANK_W = PBANK_W
) (
    input  prg_mode_e         mode,
    input  logic [BANK_W-2:0] sel,
    input  logic              outer,
    input  logic              win_hi,
    input  logic [BANK_W-1:0] mask,
    output logic [BANK_W-1:0] bank
);
    logic [BANK_W-2:0] inner;

    always_comb begin
        unique case (mode)
            PM_FIX_HI: inner = win_hi ? '1 : sel;
            PM_FIX_LO: inner = win_hi ? sel : '0;
            default:   inner = {sel[BANK_W-2:1], win_hi};
        endcase
        bank = {outer, inner} & mask;
    end
endmodule

// File: rtl/chr_bank_sel.sv
module chr_bank_sel
    import bank_xlat_pkg::*;
#(
    parameter int BANK_W = CBANK_W,
    parameter int PAGE_W = CHR_PAGE_W
) (
    input  logic                     four_k,
    input  logic [BANK_W-1:0]        lo_bank,
    input  logic [BANK_W-1:0]        hi_bank,
    input  logic [PAGE_W:0]          vaddr,
    input  logic [BANK_W-1:0]        mask,
    output logic [BANK_W+PAGE_W-1:0] addr
);
    logic [BANK_W-1:0] half_bank;
    logic [BANK_W-2:0] full_bank;

    always_comb begin
        half_bank = (vaddr[PAGE_W] ? hi_bank : lo_bank) & mask;
        full_bank = lo_bank[BANK_W-1:1] & mask[BANK_W-1:1];
        if (four_k) begin
            addr = {half_bank, vaddr[PAGE_W-1:0]};
        end else begin
            addr = {full_bank, vaddr};
        end
    end
endmodule

// File: rtl/nt_line_sel.sv
module nt_line_sel
    import bank_xlat_pkg::*;
(
    input  nt_mode_e   mode,
    input  logic [1:0] vbits,
    output logic       a10
);
    always_comb begin
        unique case (mode)
            NT_ONE_LO: a10 = 1'b0;
            NT_ONE_HI: a10 = 1'b1;
            NT_VERT:   a10 = vbits[0];
            default:   a10 = vbits[1];
        endcase
    end
endmodule

// File: rtl/bank_xlat.sv
module bank_xlat
    import bank_xlat_pkg::*;
#(
    parameter int PB_W = PBANK_W,
    parameter int CB_W = CBANK_W,
    parameter int RW   = REG_W,
    localparam int CPU_W = PRG_WIN_W + 1,
    localparam int VID_W = CHR_PAGE_W + 1,
    localparam int PRG_W = PB_W + PRG_WIN_W,
    localparam int CHR_W = CB_W + CHR_PAGE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RW-1:0]    mode_reg,
    input  logic [CB_W-1:0]  pat0_reg,
    input  logic [CB_W-1:0]  pat1_reg,
    input  logic [PB_W-2:0]  prg_sel,
    input  logic [CPU_W-1:0] cpu_addr,
    input  logic [VID_W-1:0] ppu_addr,
    input  logic [PB_W-1:0]  prg_mask,
    input  logic [CB_W-1:0]  chr_mask,
    output logic [PRG_W-1:0] prg_rom_addr,
    output logic [CHR_W-1:0] chr_addr,
    output logic             nt_a10
);
    logic [PB_W-1:0]  pbank;
    logic [CHR_W-1:0] caddr;
    logic             a10;
    xlat_t            xlat_d, xlat_q;

    prg_bank_sel #(.BANK_W(PB_W)) u_prg (
        .mode   (prg_mode_e'(mode_reg[3:2])),
        .sel    (prg_sel),
        .outer  (pat0_reg[CB_W-1]),
        .win_hi (cpu_addr[CPU_W-1]),
        .mask   (prg_mask),
        .bank   (pbank)
    );

    chr_bank_sel #(.BANK_W(CB_W), .PAGE_W(CHR_PAGE_W)) u_chr (
        .four_k  (mode_reg[4]),
        .lo_bank (pat0_reg),
        .hi_bank (pat1_reg),
        .vaddr   (ppu_addr),
        .mask    (chr_mask),
        .addr    (caddr)
    );

    nt_line_sel u_nt (
        .mode  (nt_mode_e'(mode_reg[1:0])),
        .vbits (ppu_addr[11:10]),
        .a10   (a10)
    );

    always_comb begin
        xlat_d     = '0;
        xlat_d.prg = {pbank, cpu_addr[PRG_WIN_W-1:0]};
        xlat_d.chr = caddr;
        xlat_d.nt  = a10;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xlat_q <= '0;
        end else begin
            xlat_q <= xlat_d;
        end
    end

    assign prg_rom_addr = xlat_q.prg;
    assign chr_addr     = xlat_q.chr;
    assign nt_a10       = xlat_q.nt;
endmodule

// File: rtl/bank_xlat_chk.sv
module bank_xlat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  mode_reg,
    input logic [4:0]  pat0_reg,
    input logic [3:0]  prg_sel,
    input logic [14:0] cpu_addr,
    input logic [12:0] ppu_addr,
    input logic [4:0]  prg_mask,
    input logic [18:0] prg_rom_addr,
    input logic [16:0] chr_addr,
    input logic        nt_a10
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> prg_rom_addr[13:0] == $past(cpu_addr[13:0]));

    // R7
    prg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (prg_rom_addr[18:14] & ~$past(prg_mask)) == 5'd0);

    // R3
    fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(mode_reg[3:2]) == 2'b11 && $past(cpu_addr[14]))
        |-> prg_rom_addr[18:14] == ({$past(pat0_reg[4]), 4'hF} & $past(prg_mask)));

    // R4
    fixed_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(mode_reg[3:2]) == 2'b10 && !$past(cpu_addr[14]))
        |-> prg_rom_addr[18:14] == ({$past(pat0_reg[4]), 4'h0} & $past(prg_mask)));

    // R10
    single_screen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(mode_reg[1]) == 1'b0) |-> nt_a10 == $past(mode_reg[0]));

    // R10
    vert_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(mode_reg[1:0]) == 2'b10) |-> nt_a10 == $past(ppu_addr[10]));

    // R9
    full_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(mode_reg[4])) |-> chr_addr[12:0] == $past(ppu_addr));

    // R8
    half_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(mode_reg[4])) |-> chr_addr[11:0] == $past(ppu_addr[11:0]));
endmodule

bind bank_xlat bank_xlat_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_reg     (mode_reg),
    .pat0_reg     (pat0_reg),
    .prg_sel      (prg_sel),
    .cpu_addr     (cpu_addr),
    .ppu_addr     (ppu_addr),
    .prg_mask     (prg_mask),
    .prg_rom_addr (prg_rom_addr),
    .chr_addr     (chr_addr),
    .nt_a10       (nt_a10)
);

// File: tb/bank_xlat_test.sv
`timescale 1ns/1ps
module bank_xlat_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_reg = '0, pat0_reg = '0, pat1_reg = '0;
    logic [3:0]  prg_sel = '0;
    logic [14:0] cpu_addr = '0;
    logic [12:0] ppu_addr = '0;
    logic [4:0]  prg_mask = '1, chr_mask = '1;
    logic [18:0] prg_rom_addr;
    logic [16:0] chr_addr;
    logic        nt_a10;

    int applied = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        logic [18:0] prg;
        logic [16:0] chr;
        logic        nt;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    bank_xlat uut (.*);

    function automatic logic [4:0] ref_prg_bank(input logic [4:0] m, input logic [3:0] r,
                                                input logic o, input logic w, input logic [4:0] k);
        int offs = o ? 16 : 0;
        int b;
        case (m[3:2])
            2'b11:   b = w ? 15 + offs : r + offs;
            2'b10:   b = w ? r + offs : offs;
            default: b = (r & 4'hE) + offs + (w ? 1 : 0);
        endcase
        return 5'(b) & k;
    endfunction

    function automatic logic [16:0] ref_chr(input logic [4:0] m, input logic [4:0] p0,
                                            input logic [4:0] p1, input logic [12:0] v,
                                            input logic [4:0] k);
        logic [4:0] b4;
        logic [3:0] b8;
        if (m[4]) begin
            b4 = (v[12] ? p1 : p0) & k;
            return (17'(b4) << 12) | 17'(v[11:0]);
        end
        b8 = 4'(p0 >> 1) & 4'(k >> 1);
        return (17'(b8) << 13) | 17'(v);
    endfunction

    function automatic logic ref_nt(input logic [4:0] m, input logic [12:0] v);
        case (m[1:0])
            2'd0: return 1'b0;
            2'd1: return 1'b1;
            2'd2: return v[10];
            default: return v[11];
        endcase
    endfunction

    task automatic apply(input string tag, input logic [4:0] m, input logic [4:0] p0,
                         input logic [4:0] p1, input logic [3:0] r, input logic [14:0] ca,
                         input logic [12:0] va, input logic [4:0] pk, input logic [4:0] ck);
        exp_t e;
        @(negedge clk);
        mode_reg = m; pat0_reg = p0; pat1_reg = p1; prg_sel = r;
        cpu_addr = ca; ppu_addr = va; prg_mask = pk; chr_mask = ck;
        e.tag = tag;
        e.prg = {ref_prg_bank(m, r, p0[4], ca[14], pk), ca[13:0]};
        e.chr = ref_chr(m, p0, p1, va, ck);
        e.nt  = ref_nt(m, va);
        sb.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                applied++;
                if (prg_rom_addr !== e.prg || chr_addr !== e.chr || nt_a10 !== e.nt) begin
                    bad++;
                    $display("FAIL %s: prg=%h chr=%h nt=%b expected prg=%h chr=%h nt=%b",
                             e.tag, prg_rom_addr, chr_addr, nt_a10, e.prg, e.chr, e.nt);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R1: watchdog expired, actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin : driver
        // R1: reset holds outputs at zero even with active inputs
        mode_reg = 5'h1F; pat0_reg = 5'h1F; cpu_addr = 15'h7FFF; ppu_addr = 13'h1FFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        applied++;
        if (prg_rom_addr !== '0 || chr_addr !== '0 || nt_a10 !== 1'b0) begin
            bad++;
            $display("FAIL R1: reset prg=%h chr=%h nt=%b expected all zero",
                     prg_rom_addr, chr_addr, nt_a10);
        end
        rst_n = 1'b1;

        // R3 fixed top window
        apply("R3", 5'b01100, 5'd0, 5'd0, 4'd5, 15'h0123, 13'h0000, 5'h1F, 5'h1F);
        apply("R3", 5'b01100, 5'd0, 5'd0, 4'd5, 15'h4ABC, 13'h0000, 5'h1F, 5'h1F);
        // R4 fixed bottom window
        apply("R4", 5'b01000, 5'd0, 5'd0, 4'd9, 15'h1F00, 13'h0000, 5'h1F, 5'h1F);
        apply("R4", 5'b01000, 5'd0, 5'd0, 4'd9, 15'h7F00, 13'h0000, 5'h1F, 5'h1F);
        // R5 32K pair, both low mode codes
        apply("R5", 5'b00000, 5'd0, 5'd0, 4'd7, 15'h0001, 13'h0000, 5'h1F, 5'h1F);
        apply("R5", 5'b00100, 5'd0, 5'd0, 4'd7, 15'h4002, 13'h0000, 5'h1F, 5'h1F);
        // R6 outer bank in each program mode
        apply("R6", 5'b01100, 5'h10, 5'd0, 4'd2, 15'h4000, 13'h0000, 5'h1F, 5'h1F);
        apply("R6", 5'b01000, 5'h10, 5'd0, 4'd2, 15'h0000, 13'h0000, 5'h1F, 5'h1F);
        apply("R6", 5'b00000, 5'h10, 5'd0, 4'd3, 15'h4000, 13'h0000, 5'h1F, 5'h1F);
        // R7 narrow program memory
        apply("R7", 5'b01100, 5'h10, 5'd0, 4'd13, 15'h4000, 13'h0000, 5'h07, 5'h1F);
        apply("R7", 5'b01100, 5'd0, 5'd0, 4'd13, 15'h0000, 13'h0000, 5'h01, 5'h1F);
        // R2 offset pass-through
        apply("R2", 5'b01100, 5'd0, 5'd0, 4'd1, 15'h3FFF, 13'h0000, 5'h1F, 5'h1F);
        // R8 two 4K halves, with mask
        apply("R8", 5'b10000, 5'd6, 5'd25, 4'd0, 15'h0000, 13'h0ABC, 5'h1F, 5'h1F);
        apply("R8", 5'b10000, 5'd6, 5'd25, 4'd0, 15'h0000, 13'h1ABC, 5'h1F, 5'h1F);
        apply("R8", 5'b10000, 5'd6, 5'd25, 4'd0, 15'h0000, 13'h1123, 5'h07, 5'h07);
        // R9 single 8K bank; pat1 must not matter
        apply("R9", 5'b00000, 5'd7, 5'd0, 4'd0, 15'h0000, 13'h1234, 5'h1F, 5'h1F);
        apply("R9", 5'b00000, 5'd7, 5'd31, 4'd0, 15'h0000, 13'h1234, 5'h1F, 5'h1F);
        apply("R9", 5'b00000, 5'd31, 5'd0, 4'd0, 15'h0000, 13'h0FFF, 5'h1F, 5'h03);
        // R10 all mirror settings
        apply("R10", 5'b00000, 5'd0, 5'd0, 4'd0, 15'h0000, 13'h0C00, 5'h1F, 5'h1F);
        apply("R10", 5'b00001, 5'd0, 5'd0, 4'd0, 15'h0000, 13'h0000, 5'h1F, 5'h1F);
        apply("R10", 5'b00010, 5'd0, 5'd0, 4'd0, 15'h0000, 13'h0400, 5'h1F, 5'h1F);
        apply("R10", 5'b00010, 5'd0, 5'd0, 4'd0, 15'h0000, 13'h0800, 5'h1F, 5'h1F);
        apply("R10", 5'b00011, 5'd0, 5'd0, 4'd0, 15'h0000, 13'h0800, 5'h1F, 5'h1F);
        apply("R10", 5'b00011, 5'd0, 5'd0, 4'd0, 15'h0000, 13'h0400, 5'h1F, 5'h1F);

        // R1 back-to-back mixed vectors, each seen exactly one cycle later
        for (int i = 0; i < 300; i++) begin
            apply("R1", 5'($urandom), 5'($urandom), 5'($urandom), 4'($urandom),
                  15'($urandom), 13'($urandom), 5'($urandom), 5'($urandom));
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule